// File: doc/BRIEF.md
# Multichannel Attenuator with Muting and Polarity

This block scales a stream of signed audio samples belonging to eight channels, grouped as four stereo pairs. Each sample comes in with a channel index and a valid strobe. It leaves a fixed number of cycles later with the same index, after four steps: word-width masking, a logarithmic attenuation chosen per channel, muting, and an optional sign flip shared by all channels.

A byte-wide write port sets the configuration. Address 0 holds the shared controls: bit 0 is a mute for all channels, bit 1 inverts the output polarity, and bits 3:2 select the word width. Address 1 holds the per-channel mute mask. Addresses 2 to 9 hold the attenuation codes for channels 0 to 7. Writes to any other address are dropped. Each attenuation code is looked up in a table computed at elaboration, which returns a Q1.17 linear gain. The product with that gain is rounded and then saturated.

Top module: `audio_atten_top`

## Requirements
- R1: Attenuation code 0 passes the width-masked sample through unchanged (gain 131072 in Q1.17).
- R2: For codes N from 1 to 254 the gain is round(131072·10^(−0.375·N/20)). The output is (sample·gain + 65536) shifted arithmetically right by 17.
- R3: Attenuation code 255 gives an output of exactly zero.
- R4: Bit 0 at address 0, when set, forces every channel's output to zero.
- R5: Bit i at address 1 mutes channel i. Channel 0 is the left side of pair 1 and channel 1 its right side, up to channel 7, the right side of pair 4. Other channels are unaffected.
- R6: Bit 1 at address 0 negates every output. A result that cannot be represented saturates, so −8388608 maps to 8388607.
- R7: Bits 3:2 at address 0 select the word width: 00 for 24 bits, 01 for 20 and 11 for 16. The sample is taken as left-aligned, and the unused low bits are cleared before scaling.
- R8: Writing the width code 10 leaves the previous width in force. The other bits of that write still take effect.
- R9: A write takes effect from the next valid sample. A sample presented in the same cycle as the write uses the old setting.
- R10: Each sample appears exactly 3 clock edges after it is accepted, with its channel index. The output data is zero whenever the output valid is low.
- R11: After reset, all codes are 0, no mutes are set, polarity is normal, the width is 24 bits and the output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration address |
| cfg_wdata_i | input | 8 | Configuration write data |
| in_valid_i | input | 1 | Input sample valid |
| in_chan_i | input | 3 | Input channel index |
| in_data_i | input | 24 | Input sample, two's complement |
| out_valid_o | output | 1 | Output sample valid |
| out_chan_o | output | 3 | Output channel index |
| out_data_o | output | 24 | Output sample, two's complement |

## Verification
The bench uses the default parameters: 24-bit samples, eight channels, 8-bit codes and 17 fractional gain bits. With these values the full code range, including the full-cut code 255, can be reached. So can both extremes of a 24-bit sample, and with them the saturation case where the most negative value is negated. Every mask bit can be driven on its own channel. All three legal widths and the reserved one can be checked against an independent floating-point gain model.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int DATA_W    = 24;
  localparam int NUM_CH    = 8;
  localparam int CODE_W    = 8;
  localparam int COEF_FRAC = 17;
  localparam int ADDR_W    = 4;
  localparam int WDATA_W   = 8;
  localparam real DB_STEP  = 0.375;

  localparam int ADDR_GLOBAL = 0;
  localparam int ADDR_MASK   = 1;
  localparam int ADDR_CODE0  = 2;

  typedef enum logic [1:0] {
    WID_24  = 2'b00,
    WID_20  = 2'b01,
    WID_RSV = 2'b10,
    WID_16  = 2'b11
  } width_e;
endpackage

// File: rtl/atten_cfg_regs.sv
module atten_cfg_regs
  import atten_pkg::*;
#(
  parameter int NCH   = NUM_CH,
  parameter int CW    = CODE_W,
  parameter int AW    = ADDR_W,
  parameter int WDW   = WDATA_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [WDW-1:0]         wdata_i,
  output logic                   mute_all_o,
  output logic                   invert_o,
  output width_e                 width_o,
  output logic [NCH-1:0]         ch_mute_o,
  output logic [NCH-1:0][CW-1:0] codes_o
);
  logic hit_global, hit_mask;
  assign hit_global = we_i && (addr_i == AW'(ADDR_GLOBAL));
  assign hit_mask   = we_i && (addr_i == AW'(ADDR_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_all_o <= 1'b0;
      invert_o   <= 1'b0;
      width_o    <= WID_24;
    end else if (hit_global) begin
      mute_all_o <= wdata_i[0];
      invert_o   <= wdata_i[1];
      if (wdata_i[3:2] != WID_RSV) width_o <= width_e'(wdata_i[3:2]);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         ch_mute_o[c] <= 1'b0;
      else if (hit_mask)   ch_mute_o[c] <= wdata_i[c];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) codes_o[c] <= '0;
      else if (we_i && addr_i == AW'(ADDR_CODE0 + c)) codes_o[c] <= wdata_i[CW-1:0];
    end
  end
endmodule

// File: rtl/atten_gain_rom.sv
module atten_gain_rom
  import atten_pkg::*;
#(
  parameter int CW   = CODE_W,
  parameter int FRAC = COEF_FRAC,
  localparam int GW  = FRAC + 1,
  localparam int NE  = 2 ** CW
) (
  input  logic [CW-1:0] code_i,
  output logic [GW-1:0] coef_o
);
  logic [GW-1:0] tbl [NE];

  for (genvar i = 0; i < NE; i++) begin : g_ent
    if (i == NE - 1) begin : g_cut
      assign tbl[i] = '0;
    end else begin : g_lin
      localparam real LIN = $pow(10.0, -(DB_STEP * i) / 20.0);
      localparam int unsigned Q = $rtoi(LIN * real'(1 << FRAC) + 0.5);
      assign tbl[i] = GW'(Q);
    end
  end

  assign coef_o = tbl[code_i];
endmodule

// File: rtl/atten_datapath.sv
module atten_datapath
  import atten_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NCH  = NUM_CH,
  parameter int CW   = CODE_W,
  parameter int FRAC = COEF_FRAC,
  localparam int CHW = $clog2(NCH),
  localparam int GW  = FRAC + 1,
  localparam int PW  = DW + GW + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic [CHW-1:0]         in_chan_i,
  input  logic [DW-1:0]          in_data_i,
  input  logic                   mute_all_i,
  input  logic                   invert_i,
  input  width_e                 width_i,
  input  logic [NCH-1:0]         ch_mute_i,
  input  logic [NCH-1:0][CW-1:0] codes_i,
  output logic                   out_valid_o,
  output logic [CHW-1:0]         out_chan_o,
  output logic [DW-1:0]          out_data_o
);
  localparam logic signed [PW:0] POS_MAX = (PW+1)'((1 << (DW - 1)) - 1);
  localparam logic signed [PW:0] NEG_MIN = -(PW+1)'(1 << (DW - 1));

  // stage 0: width mask, gain lookup, mute decision, config snapshot
  logic [CW-1:0] code_sel;
  logic [GW-1:0] coef_sel;
  logic [DW-1:0] mask;

  assign code_sel = codes_i[in_chan_i];

  atten_gain_rom #(.CW(CW), .FRAC(FRAC)) u_rom (
    .code_i (code_sel),
    .coef_o (coef_sel)
  );

  always_comb begin
    unique case (width_i)
      WID_20:  mask = {DW{1'b1}} << (DW - 20);
      WID_16:  mask = {DW{1'b1}} << (DW - 16);
      default: mask = {DW{1'b1}};
    endcase
  end

  logic           s0_valid, s0_mute, s0_inv;
  logic [CHW-1:0] s0_chan;
  logic [DW-1:0]  s0_data;
  logic [GW-1:0]  s0_coef;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_valid <= 1'b0;
      s0_chan  <= '0;
      s0_data  <= '0;
      s0_coef  <= '0;
      s0_mute  <= 1'b0;
      s0_inv   <= 1'b0;
    end else begin
      s0_valid <= in_valid_i;
      if (in_valid_i) begin
        s0_chan <= in_chan_i;
        s0_data <= in_data_i & mask;
        s0_coef <= coef_sel;
        s0_mute <= mute_all_i | ch_mute_i[in_chan_i] | (&code_sel);
        s0_inv  <= invert_i;
      end
    end
  end

  // stage 1: multiply and round half up
  logic signed [PW-1:0] prod, rnd;
  assign prod = $signed(s0_data) * $signed({1'b0, s0_coef}) + PW'(1 << (FRAC - 1));
  assign rnd  = prod >>> FRAC;

  logic                 s1_valid, s1_mute, s1_inv;
  logic [CHW-1:0]       s1_chan;
  logic signed [PW-1:0] s1_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_chan  <= '0;
      s1_val   <= '0;
      s1_mute  <= 1'b0;
      s1_inv   <= 1'b0;
    end else begin
      s1_valid <= s0_valid;
      if (s0_valid) begin
        s1_chan <= s0_chan;
        s1_val  <= rnd;
        s1_mute <= s0_mute;
        s1_inv  <= s0_inv;
      end
    end
  end

  // stage 2: polarity, saturation, mute
  logic signed [PW:0]   pol;
  logic signed [DW-1:0] sat;
  assign pol = s1_inv ? -(PW+1)'(s1_val) : (PW+1)'(s1_val);

  always_comb begin
    if (pol > POS_MAX)      sat = DW'(POS_MAX);
    else if (pol < NEG_MIN) sat = DW'(NEG_MIN);
    else                    sat = DW'(pol);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_chan_o  <= '0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= s1_valid;
      out_chan_o  <= s1_valid ? s1_chan : '0;
      out_data_o  <= (s1_valid && !s1_mute) ? sat : '0;
    end
  end
endmodule

// File: rtl/audio_atten_top.sv
module audio_atten_top
  import atten_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NCH  = NUM_CH,
  parameter int CW   = CODE_W,
  parameter int FRAC = COEF_FRAC,
  parameter int AW   = ADDR_W,
  localparam int CHW = $clog2(NCH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [AW-1:0]      cfg_addr_i,
  input  logic [WDATA_W-1:0] cfg_wdata_i,
  input  logic               in_valid_i,
  input  logic [CHW-1:0]     in_chan_i,
  input  logic [DW-1:0]      in_data_i,
  output logic               out_valid_o,
  output logic [CHW-1:0]     out_chan_o,
  output logic [DW-1:0]      out_data_o
);
  logic                   mute_all, invert;
  width_e                 width;
  logic [NCH-1:0]         ch_mute;
  logic [NCH-1:0][CW-1:0] codes;

  atten_cfg_regs #(.NCH(NCH), .CW(CW), .AW(AW), .WDW(WDATA_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .mute_all_o (mute_all),
    .invert_o   (invert),
    .width_o    (width),
    .ch_mute_o  (ch_mute),
    .codes_o    (codes)
  );

  atten_datapath #(.DW(DW), .NCH(NCH), .CW(CW), .FRAC(FRAC)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_chan_i   (in_chan_i),
    .in_data_i   (in_data_i),
    .mute_all_i  (mute_all),
    .invert_i    (invert),
    .width_i     (width),
    .ch_mute_i   (ch_mute),
    .codes_i     (codes),
    .out_valid_o (out_valid_o),
    .out_chan_o  (out_chan_o),
    .out_data_o  (out_data_o)
  );
endmodule

// File: rtl/audio_atten_chk.sv
module audio_atten_chk #(
  parameter int DW  = 24,
  parameter int CHW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           in_valid_i,
  input logic [CHW-1:0] in_chan_i,
  input logic [DW-1:0]  in_data_i,
  input logic           out_valid_o,
  input logic [CHW-1:0] out_chan_o,
  input logic [DW-1:0]  out_data_o
);
  logic [2:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            since_rst <= '0;
    else if (since_rst < 4) since_rst <= since_rst + 3'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < 3) |-> !out_valid_o); // R11
  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 4) |-> (out_valid_o == $past(in_valid_i, 3))); // R10
  AST_CHAN_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 4 && out_valid_o) |-> (out_chan_o == $past(in_chan_i, 3))); // R10
  AST_ZERO_STAYS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 4 && out_valid_o && $past(in_data_i, 3) == '0) |-> (out_data_o == '0)); // R2
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_data_o == '0)); // R10
endmodule

bind audio_atten_top audio_atten_chk #(.DW(DW), .CHW(CHW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_chan_i   (in_chan_i),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_chan_o  (out_chan_o),
  .out_data_o  (out_data_o)
);

// File: tb/sim_audio_atten_top.sv
module sim_audio_atten_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        in_valid_i = 1'b0;
  logic [2:0]  in_chan_i = '0;
  logic [23:0] in_data_i = '0;
  logic        out_valid_o;
  logic [2:0]  out_chan_o;
  logic [23:0] out_data_o;

  always #2 clk_i = ~clk_i;

  audio_atten_top u0 (.*);

  typedef struct {
    int          chan;
    logic [23:0] data;
    int          cyc;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0, cyc = 0;

  // bench model of configuration
  bit       m_mute_all = 0, m_inv = 0;
  bit [1:0] m_width = 2'b00;
  bit [7:0] m_mask = 0;
  int       m_code[8] = '{default: 0};

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [23:0] model(int ch, logic [23:0] d);
    longint s, p, g;
    logic [23:0] m;
    m = d;
    if (m_width == 2'b01) m[3:0] = '0;
    if (m_width == 2'b11) m[7:0] = '0;
    if (m_mute_all || m_mask[ch] || m_code[ch] == 255) return '0;
    s = longint'($signed(m));
    g = longint'($rtoi($pow(10.0, -(0.375 * m_code[ch]) / 20.0) * 131072.0 + 0.5));
    p = (s * g + 65536) >>> 17;
    if (m_inv) p = -p;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return p[23:0];
  endfunction

  procedure_check: begin end

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic apply_model(logic [3:0] a, logic [7:0] d);
    if (a == 4'd0) begin
      m_mute_all = d[0];
      m_inv = d[1];
      if (d[3:2] != 2'b10) m_width = d[3:2];
    end else if (a == 4'd1) m_mask = d;
    else if (a >= 4'd2 && a <= 4'd9) m_code[a - 2] = d;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    apply_model(a, d);
    @(posedge clk_i); #1;
    cfg_we_i = 0;
  endtask

  task automatic send(int ch, logic [23:0] d, string req);
    exp_t e;
    e.chan = ch; e.data = model(ch, d); e.cyc = cyc; e.req = req;
    exp_q.push_back(e);
    in_valid_i = 1; in_chan_i = 3'(ch); in_data_i = d;
    @(posedge clk_i); #1;
    in_valid_i = 0;
  endtask

  // write and sample in the same cycle: sample sees old config
  task automatic wr_send(logic [3:0] a, logic [7:0] wd, int ch, logic [23:0] d, string req);
    exp_t e;
    e.chan = ch; e.data = model(ch, d); e.cyc = cyc; e.req = req;
    exp_q.push_back(e);
    apply_model(a, wd);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = wd;
    in_valid_i = 1; in_chan_i = 3'(ch); in_data_i = d;
    @(posedge clk_i); #1;
    cfg_we_i = 0; in_valid_i = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(posedge clk_i);
    #1;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R10", "unexpected output", out_data_o, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_data_o == e.data, e.req, "data", out_data_o, e.data);
        check(int'(out_chan_o) == e.chan && cyc - e.cyc == 3, "R10", "chan/latency",
              (longint'(out_chan_o) << 8) | (cyc - e.cyc), (longint'(e.chan) << 8) | 3);
      end
    end else if (rst_ni && out_data_o != '0) begin
      check(0, "R10", "idle data", out_data_o, 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    check(0, "WDOG", "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i); #1;
    check(out_valid_o == 0 && out_data_o == 0, "R11", "reset outputs", out_valid_o, 0);
    rst_ni = 1;
    @(posedge clk_i); #1;
    // R11 defaults and R1 unity
    send(0, 24'h123456, "R11");
    send(7, 24'h800000, "R1");
    send(3, 24'h7FFFFF, "R1");
    send(5, 24'hFFFFFF, "R1");
    drain();
    // R2 graded codes
    wr(4'd2, 8'd1);   wr(4'd3, 8'd16);  wr(4'd4, 8'd100); wr(4'd5, 8'd254);
    send(0, 24'h7FFFFF, "R2");
    send(1, 24'h800000, "R2");
    send(2, 24'h400001, "R2");
    send(3, 24'h7FFFFF, "R2");
    send(1, 24'h000003, "R2");
    send(2, 24'hFFFFFB, "R2");
    // R3 full cut
    wr(4'd6, 8'd255);
    send(4, 24'h7FFFFF, "R3");
    send(4, 24'h800000, "R3");
    drain();
    // R4 master mute
    wr(4'd0, 8'h01);
    for (int c = 0; c < 8; c++) send(c, 24'h5A5A5A, "R4");
    wr(4'd0, 8'h00);
    send(7, 24'h5A5A5A, "R4");
    drain();
    // R5 per-channel mask
    wr(4'd1, 8'b0000_0100);
    send(2, 24'h300000, "R5");
    send(3, 24'h300000, "R5");
    send(6, 24'h300000, "R5");
    wr(4'd1, 8'b1000_0001);
    send(7, 24'h111111, "R5");
    send(0, 24'h111111, "R5");
    send(6, 24'h111111, "R5");
    wr(4'd1, 8'h00);
    drain();
    // R6 polarity with saturation
    wr(4'd0, 8'h02);
    send(6, 24'h800000, "R6");
    send(6, 24'd1000, "R6");
    send(0, 24'h7FFFFF, "R6");
    send(7, 24'hFFFC18, "R6");
    wr(4'd0, 8'h00);
    drain();
    // R7 widths
    wr(4'd0, 8'h04);
    send(7, 24'h7ABCDE, "R7");
    send(6, 24'h80000F, "R7");
    wr(4'd0, 8'h0C);
    send(7, 24'h7ABCDE, "R7");
    send(1, 24'hC234FF, "R7");
    // R8 reserved width keeps 16, other bits still apply
    wr(4'd0, 8'h0A);
    send(7, 24'h7ABCDE, "R8");
    send(0, 24'h12345F, "R8");
    wr(4'd0, 8'h00);
    drain();
    // R9 write in same cycle as sample
    wr_send(4'd9, 8'd255, 7, 24'h222222, "R9");
    send(7, 24'h222222, "R9");
    wr_send(4'd0, 8'h01, 1, 24'h444444, "R9");
    send(1, 24'h444444, "R9");
    wr(4'd0, 8'h00);
    wr(4'd9, 8'd0);
    // R10 back-to-back stream over all channels
    for (int c = 0; c < 8; c++) send(c, 24'(32'h10000 * (c + 1) + c), "R10");
    // writes to unmapped address are dropped
    wr(4'd12, 8'hFF);
    send(0, 24'h7FFFFF, "R2");
    drain();
    check(exp_q.size() == 0, "R10", "missing outputs", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule